// File: doc/BRIEF.md
# Dual-Mode Context Memory Broadcaster

This block holds the configuration words for an 8x8 array of SIMD cells and sends one configuration plane at a time to the array over a wide context bus. It has two storage blocks. One feeds row-oriented broadcasts and the other feeds column-oriented broadcasts. Each block is made of eight lanes, one per row or column, and each lane holds sixteen 32-bit words. A plane is the set of eight words that share an index within one block. Two blocks of sixteen indices give 32 planes.

A broadcast command names the orientation, the plane index and, if wanted, a single row or column. One cycle later the eight words of that plane appear on the bus and the per-cell load strobes fire for that one cycle. In row orientation a cell takes the lane of its row. In column orientation it takes the lane of its column. A DMA stream can write words through a separate port in any cycle, including a cycle with a broadcast.

Top module: `ctxb_broadcaster`

## Requirements
- R1: After a synchronous active-low reset, `ctx_valid` is 0, `cell_load` is all zeros, `ctx_mode` is 0 and `ctx_bus` is all zeros.
- R2: A write with `wr_en`=1 stores `wr_data` in block `wr_block` (0 = row block, 1 = column block), lane `wr_set` and index `wr_idx`. A later broadcast of that block and index shows the word on bus bits [32*s+31:32*s], where s is the lane.
- R3: A command on `bc_go`, sampled at a clock edge, produces `ctx_valid`=1, the plane data and the strobes at the outputs right after the next edge. This lasts for exactly one cycle per command, and back-to-back commands give back-to-back results.
- R4: With `bc_mode`=0 (row), the bus carries the row block at index `bc_plane`, `ctx_mode` is 0, and strobe bit r*8+c is set for every cell (row r, column c). The cell takes lane r.
- R5: With `bc_mode`=1 (column), the bus carries the column block at index `bc_plane`, `ctx_mode` is 1, and all 64 strobes fire. The cell at row r, column c takes lane c.
- R6: In row mode with `bc_sel_en`=1, only strobe bits r*8+c with r = `bc_sel_idx` are set, eight in all.
- R7: In column mode with `bc_sel_en`=1, only strobe bits r*8+c with c = `bc_sel_idx` are set, eight in all.
- R8: A write to the same word that a broadcast reads in the same cycle does not change that broadcast, which shows the old word. The next broadcast shows the new word.
- R9: In a cycle that does not follow a command, `ctx_valid` is 0, `cell_load` is zero and `ctx_bus` keeps the value of the last broadcast.
- R10: The two blocks are independent. Row plane k and column plane k return the words written to their own block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the DMA stream |
| wr_block | input | 1 | Target block: 0 row, 1 column |
| wr_set | input | 3 | Target lane (set) |
| wr_idx | input | 4 | Target word index within the lane |
| wr_data | input | 32 | Word to store |
| bc_go | input | 1 | Broadcast command strobe |
| bc_mode | input | 1 | Orientation: 0 row, 1 column |
| bc_plane | input | 4 | Word index that forms the plane |
| bc_sel_en | input | 1 | Enable only one row or column |
| bc_sel_idx | input | 3 | Row or column picked when `bc_sel_en` is set |
| ctx_bus | output | 256 | Eight lane words, lane s at bits [32*s+31:32*s] |
| ctx_valid | output | 1 | Bus carries a fresh plane this cycle |
| ctx_mode | output | 1 | Orientation of the plane on the bus |
| cell_load | output | 64 | Context-register load strobe, cell (r,c) at bit r*8+c |

## Verification
The bench writes every word of both blocks with a value that encodes its position. A mistake in the block, lane or index decode therefore shows up as a wrong lane on the bus. A design that read the wrong block would make the row plane and the column plane with the same index look alike. A design that swapped the strobe orientation would light a column where a row was asked for in selective mode.

A write and a broadcast to the same word in one cycle catch a design that forwards write data, because such a design shows the new word one broadcast too early. Back-to-back commands and the idle cycles after them catch a strobe that lasts more than one cycle, a latency that is off by one, and a bus that does not hold its last plane.

// File: rtl/ctxb_pkg.sv
// Shared types for the context broadcaster.
// Assumes: a single orientation bit selects both storage block and fan-out.
package ctxb_pkg;
    typedef enum logic {
        BC_ROW = 1'b0,
        BC_COL = 1'b1
    } bc_mode_e;
endpackage

// File: rtl/ctxb_bank.sv
// One storage block: LANES lanes of DEPTH words each.
// All lanes are written through one port (lane chosen by wr_set).
// All lanes are read together at a single index into a registered output.
// Assumes: a read that coincides with a write to the same word returns the
// previous content, and the output holds while no read is requested.
module ctxb_bank #(
    parameter int LANES  = 8,
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SW-1:0]           wr_set,
    input  logic [AW-1:0]           wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*WORD_W-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] mem [DEPTH];

        // Store the incoming word when this lane is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_set == SW'(g)))
                mem[wr_addr] <= wr_data;
        end

        // Capture this lane's word of the plane on a read; hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[g*WORD_W +: WORD_W] <= '0;
            else if (rd_en)
                rd_data[g*WORD_W +: WORD_W] <= mem[rd_addr];
        end
    end

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: rtl/ctxb_strobe.sv
// Fan-out of the per-cell load strobes.
// Cell (r,c) sits at bit r*LANES+c.
// In row orientation the cell belongs to lane r, in column orientation to
// lane c. With selection on, only the lane equal to sel_idx is loaded.
// Assumes: inputs are already registered. This module is purely combinational.
module ctxb_strobe #(
    parameter int LANES = 8,
    localparam int SW   = $clog2(LANES)
) (
    input  logic                     go,
    input  logic                     mode,
    input  logic                     sel_en,
    input  logic [SW-1:0]            sel_idx,
    output logic [LANES*LANES-1:0]   load
);
    for (genvar r = 0; r < LANES; r++) begin : g_row
        for (genvar c = 0; c < LANES; c++) begin : g_col
            logic [SW-1:0] lane;
            // Lane that this cell listens to under the current orientation.
            always_comb lane = (mode == ctxb_pkg::BC_COL) ? SW'(c) : SW'(r);
            // Strobe when a plane arrives and the cell's lane is enabled.
            always_comb load[r*LANES + c] = go && (!sel_en || (lane == sel_idx));
        end
    end
endmodule

// File: rtl/ctxb_broadcaster.sv
// Dual-mode context memory broadcaster (top).
// It has a row block and a column block. A command reads one index from the
// chosen block, and the next cycle drives the plane on the bus with one-cycle
// strobes to the cells.
// Assumes: writes may occur in any cycle, including broadcast cycles.
module ctxb_broadcaster #(
    parameter int LANES  = 8,
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(LANES),
    localparam int BUS_W = LANES*WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_block,
    input  logic [SW-1:0]          wr_set,
    input  logic [AW-1:0]          wr_idx,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   bc_go,
    input  logic                   bc_mode,
    input  logic [AW-1:0]          bc_plane,
    input  logic                   bc_sel_en,
    input  logic [SW-1:0]          bc_sel_idx,
    output logic [BUS_W-1:0]       ctx_bus,
    output logic                   ctx_valid,
    output logic                   ctx_mode,
    output logic [LANES*LANES-1:0] cell_load
);
    import ctxb_pkg::*;

    logic [BUS_W-1:0] blk_rd [2];
    logic             go_q;
    bc_mode_e         mode_q;
    logic             sel_en_q;
    logic [SW-1:0]    sel_idx_q;

    for (genvar b = 0; b < 2; b++) begin : g_blk
        ctxb_bank #(.LANES(LANES), .DEPTH(DEPTH), .WORD_W(WORD_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_block == 1'(b))),
            .wr_set  (wr_set),
            .wr_addr (wr_idx),
            .wr_data (wr_data),
            .rd_en   (bc_go && (bc_mode == 1'(b))),
            .rd_addr (bc_plane),
            .rd_data (blk_rd[b])
        );
    end

    // Register the command attributes so they line up with the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q      <= 1'b0;
            mode_q    <= BC_ROW;
            sel_en_q  <= 1'b0;
            sel_idx_q <= '0;
        end else begin
            go_q <= bc_go;
            if (bc_go) begin
                mode_q    <= bc_mode_e'(bc_mode);
                sel_en_q  <= bc_sel_en;
                sel_idx_q <= bc_sel_idx;
            end
        end
    end

    // Drive the bus from the block the last command read.
    always_comb ctx_bus   = blk_rd[mode_q];
    always_comb ctx_valid = go_q;
    always_comb ctx_mode  = mode_q;

    ctxb_strobe #(.LANES(LANES)) u_strobe (
        .go      (go_q),
        .mode    (mode_q),
        .sel_en  (sel_en_q),
        .sel_idx (sel_idx_q),
        .load    (cell_load)
    );

    assert_valid_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid == $past(bc_go));
    assert_full_fanout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid && !sel_en_q) |-> ($countones(cell_load) == LANES*LANES));
    assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid && sel_en_q) |-> ($countones(cell_load) == LANES));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_valid |-> (cell_load == '0));
    assert_bus_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bc_go) |-> $stable(ctx_bus));
endmodule

// File: tb/ctxb_broadcaster_bench.sv
// Scoreboard bench: the driver pushes expected planes, the monitor pops and
// compares them when the design reports a plane.
module ctxb_broadcaster_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 0, wr_block = 0;
    logic [2:0]   wr_set = 0;
    logic [3:0]   wr_idx = 0;
    logic [31:0]  wr_data = 0;
    logic         bc_go = 0, bc_mode = 0, bc_sel_en = 0;
    logic [3:0]   bc_plane = 0;
    logic [2:0]   bc_sel_idx = 0;
    logic [255:0] ctx_bus;
    logic         ctx_valid, ctx_mode;
    logic [63:0]  cell_load;

    int total = 0, bad = 0, pos_cnt = 0;
    logic [31:0]  mdl [2][8][16];
    logic [255:0] q_bus[$];
    logic [63:0]  q_load[$];
    logic         q_mode[$];
    int           q_when[$];
    string        q_tag[$];
    logic [255:0] last_bus = '0;

    always #5 clk = ~clk;
    always @(posedge clk) pos_cnt <= pos_cnt + 1;

    ctxb_broadcaster u_ctxb_broadcaster (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_block(wr_block),
        .wr_set(wr_set), .wr_idx(wr_idx), .wr_data(wr_data), .bc_go(bc_go),
        .bc_mode(bc_mode), .bc_plane(bc_plane), .bc_sel_en(bc_sel_en),
        .bc_sel_idx(bc_sel_idx), .ctx_bus(ctx_bus), .ctx_valid(ctx_valid),
        .ctx_mode(ctx_mode), .cell_load(cell_load));

    task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // One cycle of stimulus: optional write and optional broadcast.
    task automatic cyc(input bit we, input bit wb, input int ws, input int wi,
                       input logic [31:0] wd, input bit go, input bit md,
                       input int pl, input bit se, input int si, input string tag);
        @(negedge clk);
        wr_en = we; wr_block = wb; wr_set = 3'(ws); wr_idx = 4'(wi); wr_data = wd;
        bc_go = go; bc_mode = md; bc_plane = 4'(pl); bc_sel_en = se; bc_sel_idx = 3'(si);
        if (go) begin
            logic [255:0] eb;
            logic [63:0]  el;
            for (int s = 0; s < 8; s++) eb[s*32 +: 32] = mdl[md][s][pl];
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                    el[r*8+c] = !se || ((md ? c : r) == si);
            q_bus.push_back(eb); q_load.push_back(el); q_mode.push_back(md);
            q_when.push_back(pos_cnt + 1); q_tag.push_back(tag);
        end
        if (we) mdl[wb][ws][wi] = wd;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compare each reported plane with the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && ctx_valid) begin
            if (q_bus.size() == 0) begin
                chk("R3 unexpected plane", 256'(ctx_valid), 256'(0));
            end else begin
                string t = q_tag.pop_front();
                last_bus = q_bus.pop_front();
                chk({t, " bus"}, ctx_bus, last_bus);
                chk({t, " strobes"}, 256'(cell_load), 256'(q_load.pop_front()));
                chk({t, " mode"}, 256'(ctx_mode), 256'(q_mode.pop_front()));
                chk("R3 latency", 256'(pos_cnt), 256'(q_when.pop_front()));
            end
        end else if (rst_n && cell_load != 0) begin
            chk("R9 strobes without plane", 256'(cell_load), 256'(0));
        end
    end

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 valid", 256'(ctx_valid), 256'(0));
        chk("R1 strobes", 256'(cell_load), 256'(0));
        chk("R1 mode", 256'(ctx_mode), 256'(0));
        chk("R1 bus", ctx_bus, 256'(0));
        rst_n = 1'b1;
        // R2 R10: fill both blocks with position-coded words
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 8; s++)
                for (int i = 0; i < 16; i++)
                    cyc(1, b, s, i, {8'hC0 + 8'(b), 8'(s), 8'(i), 8'h5A ^ 8'(b*16+s*3+i)},
                        0, 0, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 1, 0, 3, 0, 0, "R4 R2 row plane");
        cyc(0, 0, 0, 0, 0, 1, 1, 3, 0, 0, "R5 R10 col plane");
        idle();
        cyc(0, 0, 0, 0, 0, 1, 0, 9, 1, 5, "R6 row select");
        cyc(0, 0, 0, 0, 0, 1, 1, 12, 1, 2, "R7 col select");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 back-to-back first");
        cyc(0, 0, 0, 0, 0, 1, 1, 15, 0, 0, "R3 back-to-back last");
        idle();
        // R8: write and broadcast the same word together
        cyc(1, 0, 4, 7, 32'hDEAD_BEEF, 1, 0, 7, 0, 0, "R8 old word");
        cyc(0, 0, 0, 0, 0, 1, 0, 7, 0, 0, "R8 R2 new word");
        cyc(1, 1, 0, 0, 32'h1234_5678, 0, 0, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 1, 1, 0, 1, 7, "R10 R7 col after write");
        idle();
        // R9: idle cycles hold the bus and stay quiet
        for (int k = 0; k < 3; k++) begin
            idle();
            chk("R9 valid", 256'(ctx_valid), 256'(0));
            chk("R9 strobes", 256'(cell_load), 256'(0));
            chk("R9 bus hold", ctx_bus, last_bus);
        end
        chk("R3 all planes seen", 256'(q_bus.size()), 256'(0));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule